// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command pins of a four-bank synchronous DRAM and never drives the bus. On every rising clock edge it decodes the pins into a command code. It keeps a state machine and a set of timing counters for each bank. Any command that is illegal for the addressed bank's state, or that comes too early after an earlier command, is flagged. A flagged command is treated as if it never happened: no bank state and no timer changes. The timing limits are given in picoseconds together with the clock period. At elaboration they are converted to whole cycles, rounding up.

Each bank has one state machine with four states: IDLE, OPEN (a row is active), AUTOPRE (a burst with auto-precharge is running) and PRECHG (a precharge is in progress). The transitions are:
- IDLE to OPEN on activate.
- OPEN to AUTOPRE on a read or write with auto-precharge.
- OPEN to PRECHG on precharge.
- AUTOPRE to PRECHG when the burst finishes. For a write, the burst time includes write recovery.
- PRECHG to IDLE when tRP expires, or PRECHG straight to OPEN on an activate issued in the cycle that tRP is met.

Two shared counters hold the activate-to-activate spacing across banks and the refresh lockout.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With CKE high and chip select low, the row strobe, column strobe and write-enable levels (in that order) decode as follows, and the code appears on `cmd_code`:
  - 111 is NOP (1).
  - 110 is burst stop (2).
  - 101 is read (3), or read with auto-precharge (4) when A10 is high.
  - 100 is write (5), or write with auto-precharge (6) when A10 is high.
  - 011 is activate (7).
  - 010 is precharge of one bank (8), or precharge of all banks (9) when A10 is high.
  - 001 is refresh (10).
  - 000 is mode register set (11).
  - Chip select high decodes as deselect (0).
- R2: With CKE low the pins are ignored. The code is 12, no error is raised and no bank is opened.
- R3: A read or write to a bank that is not OPEN gives cause 1. An activate to an OPEN bank gives cause 2.
- R4: A read or write issued fewer than tRCD cycles after that bank's activate gives cause 3.
- R5: A precharge that would close an OPEN bank gives one of two causes:
  - cause 4 when it comes fewer than tRAS cycles after the activate;
  - cause 8 when it comes fewer than BURST_LEN+WREC_CYC-1 cycles after a write to that bank.
- R6: An activate has three timing checks:
  - to a bank still in PRECHG before tRP has passed: cause 6;
  - within tRC of that bank's last activate: cause 7;
  - within tRRD of any activate: cause 5.
- R7: Refresh and mode register set while any bank is not idle give cause 9.
- R8: For tRFC cycles after a legal refresh, any command other than deselect, NOP or a CKE-low cycle gives cause 10.
- R9: A read with auto-precharge timeline:
  - the bank shows AUTOPRE (2) for BURST_LEN cycles, then PRECHG (3) for tRP cycles, then IDLE (0);
  - a write with auto-precharge stays in AUTOPRE WREC_CYC cycles longer;
  - any read, write, activate or precharge that targets such a bank while it is still in AUTOPRE gives cause 11.
- R10: A precharge with A10 low closes only the bank on BA. With A10 high it closes every OPEN bank.
- R11: Results appear after the clock edge that samples the command:
  - `cmd_code` and the error outputs are registered and refer to the command at that edge;
  - `err_pulse` is high for that one cycle with a nonzero cause;
  - a flagged command changes no bank state;
  - after reset all banks are IDLE and there is no error.
- R12: When several rules are broken, the lowest-ranked cause in this order is reported:
  - refresh lockout;
  - auto-precharge busy;
  - bank not open or already open;
  - tRP, tRC, tRRD for activate;
  - tRCD for read and write;
  - tRAS before write recovery for precharge.
- R13: Every nanosecond limit becomes ceil(limit / CLK_PS) cycles, with a minimum of 1. With the defaults this gives:

  | Limit | Cycles |
  |---|---|
  | tRCD | 3 |
  | tRAS | 6 |
  | tRP | 3 |
  | tRRD | 2 |
  | tRC | 8 |
  | tRFC | 10 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-banks flag) |
| cmd_code | output | 4 | Registered decoded command |
| err_pulse | output | 1 | One-cycle flag for an illegal command |
| err_cause | output | 4 | Registered cause code, 0 when legal |
| bank_state | output | 2*NUM_BANKS | Per-bank state, two bits each, bank 0 in the low bits |

## Verification
Results for a command on the pins at edge n are all visible after edge n: the command code, the error pulse and cause, and the bank state. The bench drives each command on a falling edge and samples every output on the following falling edge. A timer that expires at edge n shows in the state from that edge on. A command at edge n sees the timer as expired only when the limit in cycles has fully elapsed.

The reference model records, for each bank and for the two shared limits, the cycle number at which each limit will be met. It compares cycle numbers rather than copying counters. Stimuli land on the first cycle where a limit is still violated and on the first cycle where it is met.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_BST   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_RDA   = 4'd4,
        CMD_WR    = 4'd5,
        CMD_WRA   = 4'd6,
        CMD_ACT   = 4'd7,
        CMD_PRE   = 4'd8,
        CMD_PALL  = 4'd9,
        CMD_REF   = 4'd10,
        CMD_MRS   = 4'd11,
        CMD_HOLD  = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTOPRE = 2'd2,
        BK_PRECHG  = 2'd3
    } bank_e;

    typedef enum logic [3:0] {
        ER_NONE         = 4'd0,
        ER_NOT_OPEN     = 4'd1,
        ER_ALREADY_OPEN = 4'd2,
        ER_TRCD         = 4'd3,
        ER_TRAS         = 4'd4,
        ER_TRRD         = 4'd5,
        ER_TRP          = 4'd6,
        ER_TRC          = 4'd7,
        ER_WREC         = 4'd8,
        ER_NOT_ALL_IDLE = 4'd9,
        ER_TRFC         = 4'd10,
        ER_AUTOPRE      = 4'd11
    } err_e;

    // Snapshot of one bank, taken from its registers only.
    typedef struct packed {
        bank_e st;
        logic  rcd_ok;
        logic  ras_ok;
        logic  rc_ok;
        logic  wr_ok;
        logic  rp_ok;
    } bank_view_t;

    // Round a picosecond limit up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke) begin
            cmd = CMD_HOLD;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b110: cmd = CMD_BST;
                3'b101: cmd = a10 ? CMD_RDA  : CMD_RD;
                3'b100: cmd = a10 ? CMD_WRA  : CMD_WR;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = a10 ? CMD_PALL : CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_guard_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int WREC      = 2,
    parameter int TRCD      = 3,
    parameter int TRAS      = 6,
    parameter int TRP       = 3,
    parameter int TRC       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_act,
    input  logic       go_rd,
    input  logic       go_wr,
    input  logic       go_ap,
    input  logic       go_pre,
    output bank_view_t view
);

    // Cycles spent in AUTOPRE after the edge that accepts the command.
    localparam int RD_HOLD = BURST_LEN - 1;
    localparam int WR_HOLD = BURST_LEN + WREC - 1;
    // Write-to-precharge distance counted from the write command.
    localparam int WR_GAP  = BURST_LEN + WREC - 2;
    localparam int MAXV    = imax(imax(imax(TRAS, TRC), imax(WR_HOLD, TRCD)), TRP);
    localparam int CW      = $clog2(MAXV + 1);

    bank_e          state_q, state_d;
    logic [CW-1:0]  tmr_q, tmr_d;
    logic [CW-1:0]  rcd_q, ras_q, rc_q, wr_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        tmr_d   = dn(tmr_q);
        unique case (state_q)
            BK_IDLE: begin
                if (go_act) state_d = BK_OPEN;
            end
            BK_OPEN: begin
                if ((go_rd || go_wr) && go_ap) begin
                    state_d = BK_AUTOPRE;
                    tmr_d   = go_wr ? CW'(WR_HOLD) : CW'(RD_HOLD);
                end else if (go_pre) begin
                    state_d = BK_PRECHG;
                    tmr_d   = CW'(TRP - 1);
                end
            end
            BK_AUTOPRE: begin
                if (tmr_q == '0) begin
                    state_d = BK_PRECHG;
                    tmr_d   = CW'(TRP - 1);
                end
            end
            BK_PRECHG: begin
                if (tmr_q == '0) state_d = go_act ? BK_OPEN : BK_IDLE;
            end
        endcase
    end

    // per-bank timing windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q <= '0;
            ras_q <= '0;
            rc_q  <= '0;
            wr_q  <= '0;
        end else begin
            rcd_q <= go_act ? CW'(TRCD - 1) : dn(rcd_q);
            ras_q <= go_act ? CW'(TRAS - 1) : dn(ras_q);
            rc_q  <= go_act ? CW'(TRC - 1)  : dn(rc_q);
            wr_q  <= go_wr  ? CW'(WR_GAP)   : dn(wr_q);
        end
    end

    // outputs
    always_comb begin
        view.st     = state_q;
        view.rcd_ok = (rcd_q == '0);
        view.ras_ok = (ras_q == '0);
        view.rc_ok  = (rc_q == '0);
        view.wr_ok  = (wr_q == '0);
        view.rp_ok  = (state_q == BK_IDLE) || (state_q == BK_PRECHG && tmr_q == '0);
    end

    p_col_needs_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd || go_wr) |-> (state_q == BK_OPEN && rcd_q == '0));

    p_close_needs_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pre && state_q == BK_OPEN) |-> (ras_q == '0 && wr_q == '0));

    p_open_needs_rp_rc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_act |-> (rc_q == '0 && (state_q == BK_IDLE || (state_q == BK_PRECHG && tmr_q == '0))));

    p_autopre_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_PRECHG && $past(state_q) == BK_AUTOPRE) |-> ($past(tmr_q) == '0));

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRRD      = 2,
    parameter int TRFC      = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] bsel,
    input  bank_view_t      views [NUM_BANKS],
    output err_e            cause
);

    localparam int RW = $clog2(imax(TRRD, TRFC) + 1);

    logic [RW-1:0] rrd_q, rfc_q;
    bank_view_t    sel;
    logic          any_ap, any_ras, any_wr, all_idle;
    logic          legal;

    function automatic logic [RW-1:0] dn(input logic [RW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        any_ap   = 1'b0;
        any_ras  = 1'b0;
        any_wr   = 1'b0;
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (views[i].st == BK_AUTOPRE)                    any_ap   = 1'b1;
            if (views[i].st == BK_OPEN && !views[i].ras_ok)   any_ras  = 1'b1;
            if (views[i].st == BK_OPEN && !views[i].wr_ok)    any_wr   = 1'b1;
            if (!views[i].rp_ok)                              all_idle = 1'b0;
        end
    end

    assign sel = views[bsel];

    // cause, in priority order
    always_comb begin
        cause = ER_NONE;
        if (rfc_q != '0 && !(cmd inside {CMD_DESEL, CMD_NOP, CMD_HOLD})) begin
            cause = ER_TRFC;
        end else begin
            unique case (cmd)
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                    if (sel.st == BK_AUTOPRE)   cause = ER_AUTOPRE;
                    else if (sel.st != BK_OPEN) cause = ER_NOT_OPEN;
                    else if (!sel.rcd_ok)       cause = ER_TRCD;
                end
                CMD_ACT: begin
                    if (sel.st == BK_AUTOPRE)   cause = ER_AUTOPRE;
                    else if (sel.st == BK_OPEN) cause = ER_ALREADY_OPEN;
                    else if (!sel.rp_ok)        cause = ER_TRP;
                    else if (!sel.rc_ok)        cause = ER_TRC;
                    else if (rrd_q != '0)       cause = ER_TRRD;
                end
                CMD_PRE: begin
                    if (sel.st == BK_AUTOPRE)                    cause = ER_AUTOPRE;
                    else if (sel.st == BK_OPEN && !sel.ras_ok)   cause = ER_TRAS;
                    else if (sel.st == BK_OPEN && !sel.wr_ok)    cause = ER_WREC;
                end
                CMD_PALL: begin
                    if (any_ap)       cause = ER_AUTOPRE;
                    else if (any_ras) cause = ER_TRAS;
                    else if (any_wr)  cause = ER_WREC;
                end
                CMD_REF, CMD_MRS: begin
                    if (!all_idle) cause = ER_NOT_ALL_IDLE;
                end
                default: cause = ER_NONE;
            endcase
        end
    end

    assign legal = (cause == ER_NONE);

    // shared windows: activate spacing and refresh lockout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            rfc_q <= '0;
        end else begin
            rrd_q <= (legal && cmd == CMD_ACT) ? RW'(TRRD - 1) : dn(rrd_q);
            rfc_q <= (legal && cmd == CMD_REF) ? RW'(TRFC - 1) : dn(rfc_q);
        end
    end

    p_lockout_blocks_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfc_q != '0 && cmd == CMD_ACT) |-> !legal);

    p_spacing_blocks_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rrd_q != '0 && cmd == CMD_ACT) |-> !legal);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_PS    = 7500,
    parameter int TRCD_PS   = 18000,
    parameter int TRAS_PS   = 42000,
    parameter int TRP_PS    = 18000,
    parameter int TRRD_PS   = 12000,
    parameter int TRC_PS    = 60000,
    parameter int TRFC_PS   = 72000,
    parameter int WREC_CYC  = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic [3:0]             cmd_code,
    output logic                   err_pulse,
    output logic [3:0]             err_cause,
    output logic [2*NUM_BANKS-1:0] bank_state
);

    localparam int C_TRCD = ps_to_cyc(TRCD_PS, CLK_PS);
    localparam int C_TRAS = ps_to_cyc(TRAS_PS, CLK_PS);
    localparam int C_TRP  = ps_to_cyc(TRP_PS,  CLK_PS);
    localparam int C_TRRD = ps_to_cyc(TRRD_PS, CLK_PS);
    localparam int C_TRC  = ps_to_cyc(TRC_PS,  CLK_PS);
    localparam int C_TRFC = ps_to_cyc(TRFC_PS, CLK_PS);

    cmd_e             cmd;
    err_e             cause;
    logic             legal;
    logic             is_col, is_ap;
    bank_view_t       views [NUM_BANKS];
    logic [NUM_BANKS-1:0] idle_now;

    cmd_e             cmd_q;
    err_e             cause_q;
    logic             err_q;

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd   (cmd)
    );

    sdram_rule_check #(
        .NUM_BANKS (NUM_BANKS),
        .TRRD      (C_TRRD),
        .TRFC      (C_TRFC)
    ) u_rules (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .bsel  (ba),
        .views (views),
        .cause (cause)
    );

    assign legal  = (cause == ER_NONE);
    assign is_col = (cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA});
    assign is_ap  = (cmd inside {CMD_RDA, CMD_WRA});

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(gi));

        sdram_bank_track #(
            .BURST_LEN (BURST_LEN),
            .WREC      (WREC_CYC),
            .TRCD      (C_TRCD),
            .TRAS      (C_TRAS),
            .TRP       (C_TRP),
            .TRC       (C_TRC)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .go_act (legal && hit && cmd == CMD_ACT),
            .go_rd  (legal && hit && (cmd == CMD_RD || cmd == CMD_RDA)),
            .go_wr  (legal && hit && (cmd == CMD_WR || cmd == CMD_WRA)),
            .go_ap  (is_ap),
            .go_pre (legal && ((hit && cmd == CMD_PRE) || cmd == CMD_PALL)),
            .view   (views[gi])
        );

        assign bank_state[2*gi +: 2] = views[gi].st;
        assign idle_now[gi]          = (views[gi].st == BK_IDLE);
    end

    // registered report of the sampled command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_DESEL;
            cause_q <= ER_NONE;
            err_q   <= 1'b0;
        end else begin
            cmd_q   <= cmd;
            cause_q <= cause;
            err_q   <= !legal;
        end
    end

    assign cmd_code  = cmd_q;
    assign err_cause = cause_q;
    assign err_pulse = err_q;

    p_hold_is_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_HOLD) |-> !err_q);

    p_refresh_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF && !err_q) |-> (&idle_now));

    p_flag_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (cause_q != ER_NONE));

    p_col_only_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && legal) |-> (views[ba].st == BK_OPEN));

endmodule

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;
    logic [3:0] cmd_code, err_cause;
    logic       err_pulse;
    logic [7:0] bank_state;

    sdram_cmd_guard u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ba         (ba),
        .a10        (a10),
        .cmd_code   (cmd_code),
        .err_pulse  (err_pulse),
        .err_cause  (err_cause),
        .bank_state (bank_state)
    );

    // R13: limits in cycles, rounded up from picoseconds at 7.5 ns
    localparam int CK    = 7500;
    localparam int T_RCD = (18000 + CK - 1) / CK;
    localparam int T_RAS = (42000 + CK - 1) / CK;
    localparam int T_RP  = (18000 + CK - 1) / CK;
    localparam int T_RRD = (12000 + CK - 1) / CK;
    localparam int T_RC  = (60000 + CK - 1) / CK;
    localparam int T_RFC = (72000 + CK - 1) / CK;
    localparam int BL    = 4;
    localparam int WRC   = 2;

    int n, checks, errors;
    bit finished;
    // model: 0 idle, 1 open, 2 auto-precharge, 3 precharging
    int mst[4], rcd_ok[4], ras_ok[4], rc_ok[4], wr_ok[4], pre_start[4], done_at[4];
    int rrd_ok, rfc_ok;

    function automatic string tag_of(input int c);
        case (c)
            0: return "R11";
            1, 2: return "R3";
            3: return "R4 R13";
            4, 8: return "R5 R13";
            5, 6, 7: return "R6 R13";
            9: return "R7";
            10: return "R8 R13";
            11: return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic int disp(input int b);
        if (mst[b] == 1) return 1;
        if (mst[b] == 2) return (n < pre_start[b]) ? 2 : (n < done_at[b]) ? 3 : 0;
        if (mst[b] == 3) return (n < done_at[b]) ? 3 : 0;
        return 0;
    endfunction

    function automatic bit ap_busy(input int b);
        return mst[b] == 2 && n <= pre_start[b];
    endfunction

    function automatic bit is_idle(input int b);
        return mst[b] == 0 || (mst[b] >= 2 && n >= done_at[b]);
    endfunction

    function automatic int exp_cmd(input bit k, input bit cs, input bit r, input bit c,
                                   input bit w, input bit a);
        if (!k) return 12;
        if (cs) return 0;
        case ({r, c, w})
            3'b111: return 1;
            3'b110: return 2;
            3'b101: return a ? 4 : 3;
            3'b100: return a ? 6 : 5;
            3'b011: return 7;
            3'b010: return a ? 9 : 8;
            3'b001: return 10;
            default: return 11;
        endcase
    endfunction

    function automatic int exp_cause(input int cmd, input int b);
        bit anyap, anyras, anywr, allidle;
        if (n < rfc_ok && !(cmd inside {0, 1, 12})) return 10;
        case (cmd)
            3, 4, 5, 6: begin
                if (ap_busy(b)) return 11;
                if (mst[b] != 1) return 1;
                if (n < rcd_ok[b]) return 3;
            end
            7: begin
                if (ap_busy(b)) return 11;
                if (mst[b] == 1) return 2;
                if (!is_idle(b)) return 6;
                if (n < rc_ok[b]) return 7;
                if (n < rrd_ok) return 5;
            end
            8: begin
                if (ap_busy(b)) return 11;
                if (mst[b] == 1 && n < ras_ok[b]) return 4;
                if (mst[b] == 1 && n < wr_ok[b]) return 8;
            end
            9: begin
                anyap = 0; anyras = 0; anywr = 0;
                for (int i = 0; i < 4; i++) begin
                    if (ap_busy(i)) anyap = 1;
                    if (mst[i] == 1 && n < ras_ok[i]) anyras = 1;
                    if (mst[i] == 1 && n < wr_ok[i]) anywr = 1;
                end
                if (anyap) return 11;
                if (anyras) return 4;
                if (anywr) return 8;
            end
            10, 11: begin
                allidle = 1;
                for (int i = 0; i < 4; i++) if (!is_idle(i)) allidle = 0;
                if (!allidle) return 9;
            end
            default: ;
        endcase
        return 0;
    endfunction

    task automatic close_bank(input int b);
        if (mst[b] == 1) begin
            mst[b] = 3;
            done_at[b] = n + T_RP;
        end
    endtask

    task automatic update(input int cmd, input int b);
        case (cmd)
            7: begin
                mst[b] = 1; rcd_ok[b] = n + T_RCD; ras_ok[b] = n + T_RAS;
                rc_ok[b] = n + T_RC; rrd_ok = n + T_RRD;
            end
            3, 5: if (cmd == 5) wr_ok[b] = n + BL + WRC - 1;
            4, 6: begin
                mst[b] = 2;
                pre_start[b] = n + BL + ((cmd == 6) ? WRC : 0);
                done_at[b] = pre_start[b] + T_RP;
            end
            8: close_bank(b);
            9: for (int i = 0; i < 4; i++) close_bank(i);
            10: rfc_ok = n + T_RFC;
            default: ;
        endcase
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, n, act, expv);
        end
    endtask

    // drive on a falling edge, compare on the next falling edge
    task automatic step(input bit k, input bit cs, input bit r, input bit c, input bit w,
                        input int b, input bit a);
        int ec, ecause;
        logic [7:0] est;
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b[1:0]; a10 = a;
        n++;
        ec = exp_cmd(k, cs, r, c, w, a);
        ecause = exp_cause(ec, b);
        if (ecause == 0) update(ec, b);
        @(negedge clk);
        for (int i = 0; i < 4; i++) est[2*i +: 2] = disp(i);
        check(cmd_code == ec[3:0], "R1 R2", "command code", cmd_code, ec);
        check(err_pulse == (ecause != 0) && err_cause == ecause[3:0],
              {tag_of(ecause), " R12"}, "error cause", err_cause, ecause);
        check(bank_state == est, "R9 R10 R11", "bank states", bank_state, est);
    endtask

    task automatic nop(input int k);
        for (int i = 0; i < k; i++) step(1, 0, 1, 1, 1, 0, 0);
    endtask
    task automatic act(input int b);           step(1, 0, 0, 1, 1, b, 0); endtask
    task automatic rd(input int b, input bit a); step(1, 0, 1, 0, 1, b, a); endtask
    task automatic wr(input int b, input bit a); step(1, 0, 1, 0, 0, b, a); endtask
    task automatic pre(input int b);           step(1, 0, 0, 1, 0, b, 0); endtask
    task automatic pall();                     step(1, 0, 0, 1, 0, 0, 1); endtask
    task automatic refr();                     step(1, 0, 0, 0, 1, 0, 0); endtask
    task automatic mrs();                      step(1, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", n);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        n = 0; checks = 0; errors = 0; finished = 0;
        rrd_ok = 0; rfc_ok = 0;
        for (int i = 0; i < 4; i++) begin
            mst[i] = 0; rcd_ok[i] = 0; ras_ok[i] = 0; rc_ok[i] = 0;
            wr_ok[i] = 0; pre_start[i] = 0; done_at[i] = 0;
        end
        rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; a10 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state
        check(err_pulse == 0 && err_cause == 0, "R11", "reset error", err_cause, 0);
        check(bank_state == 8'h00, "R11", "reset banks", bank_state, 0);

        nop(1);
        step(1, 1, 0, 0, 0, 0, 0);            // deselect
        step(1, 0, 1, 1, 0, 0, 0);            // burst stop
        step(0, 0, 0, 1, 1, 0, 0);            // R2: CKE low, activate pattern ignored
        rd(0, 0);                             // R3: bank closed
        wr(2, 0);
        act(0);
        rd(0, 0);                             // R4: too early
        act(1);
        act(0);                               // R3: already open
        wr(0, 0);
        pre(0);                               // R5: tRAS
        pre(0);                               // R5: write recovery
        nop(2);
        pre(0);
        act(0);                               // R6: tRP
        nop(1);
        act(0);
        refr();                               // R7
        mrs();
        pall();                               // R5 via all-bank close
        nop(6);
        rd(1, 1);                             // R9: read with auto-precharge
        rd(1, 0);
        pre(1);
        nop(2);
        act(1);                               // R6: still precharging
        nop(3);
        wr(0, 1);                             // R9: write with auto-precharge
        pall();
        mrs();
        nop(10);
        refr();                               // R8: lockout starts
        rd(0, 0);                             // R12: lockout outranks closed bank
        act(3);
        nop(7);
        act(3);
        act(2);                               // R6: tRRD
        act(2);
        nop(6);
        pre(3);                               // R10: single bank only
        pall();                               // R10: remaining open bank
        nop(4);
        mrs();
        step(1, 0, 1, 1, 0, 0, 0);
        nop(2);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule